// File: doc/BRIEF.md
# Sequential Multiplier with Operand-Dependent Latency

This block multiplies two 16-bit operands over many clock cycles and produces a 32-bit product. It walks the multiplier operand one bit position per clock. In unsigned mode it adds the shifted multiplicand for every 1 bit. In signed mode it uses radix-2 Booth recoding and adds or subtracts on each 0/1 boundary of the multiplier. The arithmetic finishes within 16 clocks. The block then stays busy for a cost that depends on the multiplier value, which matches the timing model of a microcoded multiply. In this design one clock equals one core cycle.

The cost is a fixed 38 core cycles plus 2 per counted bit. Unsigned mode counts the 1 bits of the multiplier. Signed mode counts the 1 bits of a boundary vector, which is the multiplier XOR itself shifted left by one place. When the operation finishes, the block reports the core-cycle total and the same total scaled by a clock-divider ratio, which gives the master-clock cost. The divider ratio is captured when the operation starts.

Top module: `mul_var_latency`

## Requirements
- R1: With `signed_mode`=0, `product` at `done` is the zero-extended 32-bit product `mcand`*`mplier`.
- R2: With `signed_mode`=1, `product` at `done` is the 32-bit two's-complement product of the sign-extended operands.
- R3: With `signed_mode`=0, `done` rises exactly 38 + 2·ones(`mplier`) clock edges after the edge that accepts `start`: 38 for 0x0000 and 70 for 0xFFFF.
- R4: With `signed_mode`=1, the latency is 38 + 2·ones(t), where t = (`mplier`<<1) XOR `mplier` truncated to 16 bits. Bit 0 of t is `mplier` bit 0, and the bit shifted out of the top is dropped. 0x5555 gives 70, 0x0001 gives 42, 0x8000 gives 40 and 0xFFFF gives 40.
- R5: `core_cycles` equals the latency of the finished operation, in core cycles, from the `done` cycle onward.
- R6: `master_cycles` equals `core_cycles` times the `clk_div` value sampled on the accepting edge. A ratio of 0 gives 0.
- R7: `done` is high for exactly one clock. `busy` rises on the accepting edge and falls on the edge where `done` rises.
- R8: A `start` seen while `busy` is high has no effect. The running operation finishes with its own result and timing, and no second `done` follows.
- R9: `product`, `core_cycles` and `master_cycles` hold their values from `done` until the next accepted `start`.
- R10: After reset, `busy`, `done`, `product`, `core_cycles` and `master_cycles` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one core cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts an operation when idle |
| signed_mode | input | 1 | 1 = signed Booth, 0 = unsigned |
| mcand | input | 16 | Multiplicand |
| mplier | input | 16 | Multiplier; also sets the latency |
| clk_div | input | 8 | Master clocks per core cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| product | output | 32 | Result |
| core_cycles | output | 7 | Core cycles consumed |
| master_cycles | output | 15 | Master clocks consumed |

## Verification
The bench targets both latency extremes of unsigned mode. An off-by-one in the edge counter would report 37/69 or 39/71, and a popcount taken from the wrong operand would make 0x0000 cost as much as 0xFFFF. In signed mode it uses 0x5555, 0x0001, 0x8000 and 0xFFFF. These catch a boundary vector that drops the implied 0 below bit 0, that keeps the carry out of the top, or that counts ones instead of boundaries. Negative operands expose a missing sign extension or a swapped Booth add/subtract. A start issued mid-operation, and idle gaps after `done`, reveal a unit that restarts, pulses twice or lets its result drift.

// File: rtl/mvl_pkg.sv
package mvl_pkg;

   typedef enum logic {
      MODE_UNS = 1'b0,
      MODE_SGN = 1'b1
   } mul_mode_e;

   function automatic int unsigned count_set(input logic [63:0] v, input int unsigned n);
      int unsigned c;
      c = 0;
      for (int unsigned i = 0; i < n; i++) c += int'(v[i]);
      return c;
   endfunction

endpackage

// File: rtl/mvl_cost.sv
module mvl_cost
   import mvl_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter int BASE_CYC = 38,
   parameter int STEP_CYC = 2,
   parameter int CNT_W    = 7
)(
   input  mul_mode_e          mode,
   input  logic [WIDTH-1:0]   opnd,
   output logic [CNT_W-1:0]   total
);

   logic [WIDTH-1:0] edge_vec;
   logic [WIDTH-1:0] sel_vec;
   logic [63:0]      wide_vec;
   int unsigned      n_set;

   // boundary vector: each bit marks a 0/1 change against the bit below
   for (genvar i = 0; i < WIDTH; i++) begin : g_edge
      if (i == 0) begin : g_lsb
         assign edge_vec[i] = opnd[i];
      end else begin : g_upper
         assign edge_vec[i] = opnd[i] ^ opnd[i-1];
      end
   end

   always_comb begin
      sel_vec  = (mode == MODE_SGN) ? edge_vec : opnd;
      wide_vec = 64'(sel_vec);
      n_set    = count_set(wide_vec, WIDTH);
      total    = CNT_W'(BASE_CYC + STEP_CYC * int'(n_set));
   end

endmodule

// File: rtl/mvl_booth_dp.sv
module mvl_booth_dp
   import mvl_pkg::*;
#(
   parameter int WIDTH = 16,
   localparam int PW   = 2 * WIDTH,
   localparam int SW   = $clog2(WIDTH)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  mul_mode_e        mode,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [PW-1:0]    acc
);

   logic [PW-1:0]    mc;
   logic [WIDTH-1:0] mp;
   logic             prev;
   logic             run;
   mul_mode_e        mode_q;
   logic [SW-1:0]    step;
   logic [PW-1:0]    acc_nx;

   always_comb begin
      acc_nx = acc;
      if (mode_q == MODE_SGN) begin
         case ({mp[0], prev})
            2'b10:   acc_nx = acc - mc;
            2'b01:   acc_nx = acc + mc;
            default: acc_nx = acc;
         endcase
      end else if (mp[0]) begin
         acc_nx = acc + mc;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mc     <= '0;
         mp     <= '0;
         prev   <= 1'b0;
         run    <= 1'b0;
         mode_q <= MODE_UNS;
         step   <= '0;
         acc    <= '0;
      end else if (load) begin
         mc     <= (mode == MODE_SGN) ? {{WIDTH{a[WIDTH-1]}}, a} : {{WIDTH{1'b0}}, a};
         mp     <= b;
         prev   <= 1'b0;
         run    <= 1'b1;
         mode_q <= mode;
         step   <= '0;
         acc    <= '0;
      end else if (run) begin
         acc  <= acc_nx;
         mc   <= mc << 1;
         mp   <= mp >> 1;
         prev <= mp[0];
         step <= step + 1'b1;
         if (step == SW'(WIDTH - 1)) run <= 1'b0;
      end
   end

endmodule

// File: rtl/mvl_timer.sv
module mvl_timer #(
   parameter int CNT_W = 7
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic [CNT_W-1:0] total,
   output logic             busy,
   output logic             done,
   output logic             last,
   output logic [CNT_W-1:0] tot_q
);

   logic [CNT_W-1:0] cnt;

   assign last = busy && (cnt == tot_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         cnt   <= '0;
         tot_q <= '0;
      end else if (accept) begin
         busy  <= 1'b1;
         done  <= 1'b0;
         cnt   <= CNT_W'(1);
         tot_q <= total;
      end else if (last) begin
         busy <= 1'b0;
         done <= 1'b1;
      end else begin
         done <= 1'b0;
         if (busy) cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/mul_var_latency.sv
module mul_var_latency
   import mvl_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter int DIV_W    = 8,
   parameter int BASE_CYC = 38,
   parameter int STEP_CYC = 2,
   localparam int CNT_W   = $clog2(BASE_CYC + STEP_CYC * WIDTH + 1),
   localparam int MCLK_W  = CNT_W + DIV_W,
   localparam int PW      = 2 * WIDTH
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              signed_mode,
   input  logic [WIDTH-1:0]  mcand,
   input  logic [WIDTH-1:0]  mplier,
   input  logic [DIV_W-1:0]  clk_div,
   output logic              busy,
   output logic              done,
   output logic [PW-1:0]     product,
   output logic [CNT_W-1:0]  core_cycles,
   output logic [MCLK_W-1:0] master_cycles
);

   if (WIDTH < 2 || WIDTH > 32) begin : g_bad_width
      $error("mul_var_latency: WIDTH out of range");
   end
   if (BASE_CYC <= WIDTH) begin : g_bad_base
      $error("mul_var_latency: BASE_CYC must exceed WIDTH so the product settles first");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("mul_var_latency: DIV_W must be positive");
   end

   mul_mode_e        mode_in;
   logic             accept;
   logic [CNT_W-1:0] total_c;
   logic [CNT_W-1:0] tot_q;
   logic             last;
   logic [PW-1:0]    acc;
   logic [DIV_W-1:0] div_q;

   assign mode_in = signed_mode ? MODE_SGN : MODE_UNS;
   assign accept  = start && !busy;

   mvl_cost #(
      .WIDTH(WIDTH), .BASE_CYC(BASE_CYC), .STEP_CYC(STEP_CYC), .CNT_W(CNT_W)
   ) u_cost (
      .mode(mode_in), .opnd(mplier), .total(total_c)
   );

   mvl_booth_dp #(.WIDTH(WIDTH)) u_dp (
      .clk(clk), .rst_n(rst_n), .load(accept), .mode(mode_in),
      .a(mcand), .b(mplier), .acc(acc)
   );

   mvl_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .accept(accept), .total(total_c),
      .busy(busy), .done(done), .last(last), .tot_q(tot_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q         <= '0;
         product       <= '0;
         core_cycles   <= '0;
         master_cycles <= '0;
      end else begin
         if (accept) div_q <= clk_div;
         if (last) begin
            product       <= acc;
            core_cycles   <= tot_q;
            master_cycles <= MCLK_W'(tot_q) * MCLK_W'(div_q);
         end
      end
   end

endmodule

// File: rtl/mvl_checker.sv
module mvl_checker #(
   parameter int WIDTH    = 16,
   parameter int DIV_W    = 8,
   parameter int BASE_CYC = 38,
   parameter int STEP_CYC = 2,
   localparam int CNT_W   = $clog2(BASE_CYC + STEP_CYC * WIDTH + 1),
   localparam int MCLK_W  = CNT_W + DIV_W,
   localparam int PW      = 2 * WIDTH
)(
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [PW-1:0]     product,
   input logic [CNT_W-1:0]  core_cycles,
   input logic [MCLK_W-1:0] master_cycles
);

   logic [15:0] busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             busy_len <= '0;
      else if (start && !busy) busy_len <= '0;
      else if (busy)           busy_len <= busy_len + 1'b1;
   end

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_idle_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_busy_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(product) && $stable(core_cycles) && $stable(master_cycles)));

   assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy_len == 16'(core_cycles)));

   assert_cost_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (int'(core_cycles) >= BASE_CYC &&
                int'(core_cycles) <= BASE_CYC + STEP_CYC * WIDTH &&
                core_cycles[0] == 1'b0));

endmodule

bind mul_var_latency mvl_checker #(
   .WIDTH(WIDTH), .DIV_W(DIV_W), .BASE_CYC(BASE_CYC), .STEP_CYC(STEP_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .product(product), .core_cycles(core_cycles), .master_cycles(master_cycles)
);

// File: tb/mul_var_latency_tb.sv
module mul_var_latency_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        signed_mode = 1'b0;
   logic [15:0] mcand = '0;
   logic [15:0] mplier = '0;
   logic [7:0]  clk_div = '0;
   logic        busy;
   logic        done;
   logic [31:0] product;
   logic [6:0]  core_cycles;
   logic [14:0] master_cycles;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int t_start = 0;
   bit finished = 0;

   typedef struct {
      logic [31:0] prod;
      int          lat;
      int          mclk;
      string       tag;
   } exp_t;

   exp_t sb[$];

   always #4 clk = ~clk;   // 125 MHz
   always @(posedge clk) cyc++;

   mul_var_latency u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
      .mcand(mcand), .mplier(mplier), .clk_div(clk_div), .busy(busy),
      .done(done), .product(product), .core_cycles(core_cycles),
      .master_cycles(master_cycles)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // monitor: pop an expected item on each done pulse
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            check(0, "R8 unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(product == e.prod, {e.tag, " product"}, longint'(product), longint'(e.prod));
            check(cyc - t_start == e.lat, {e.tag, " latency"}, cyc - t_start, e.lat);
            check(int'(core_cycles) == e.lat, "R5 core_cycles", core_cycles, e.lat);
            check(int'(master_cycles) == e.mclk, "R6 master_cycles", master_cycles, e.mclk);
            check(!busy, "R7 busy low at done", busy, 0);
         end
      end
   end

   task automatic issue(input bit sm, input logic [15:0] a, input logic [15:0] b,
                        input logic [7:0] dv, input string tag);
      exp_t e;
      logic [15:0] tv;
      int ones;
      tv = (b << 1) ^ b;
      ones = sm ? $countones(tv) : $countones(b);
      e.lat  = 38 + 2 * ones;
      e.mclk = e.lat * int'(dv);
      e.tag  = tag;
      if (sm) e.prod = 32'($signed({{16{a[15]}}, a}) * $signed({{16{b[15]}}, b}));
      else    e.prod = 32'({16'h0, a}) * 32'({16'h0, b});
      sb.push_back(e);
      @(negedge clk);
      signed_mode = sm; mcand = a; mplier = b; clk_div = dv; start = 1'b1;
      t_start = cyc + 1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic run(input bit sm, input logic [15:0] a, input logic [15:0] b,
                      input logic [7:0] dv, input string tag);
      issue(sm, a, b, dv, tag);
      wait_done();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check(!busy && !done, "R10 control idle", {busy, done}, 0);
      check(product == 0 && core_cycles == 0 && master_cycles == 0, "R10 results zero",
            longint'(product) + core_cycles + master_cycles, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R3 unsigned
      run(0, 16'h1234, 16'h0000, 8'd1, "R3 R1 unsigned min");
      run(0, 16'hFFFF, 16'hFFFF, 8'd3, "R3 R1 unsigned max");
      run(0, 16'h0ABC, 16'h00F0, 8'd7, "R1 unsigned mid");
      run(0, 16'h8001, 16'h8000, 8'd0, "R1 R6 unsigned div0");

      // R2 / R4 signed
      run(1, 16'h8000, 16'h5555, 8'd2, "R4 R2 signed 5555");
      run(1, 16'h0007, 16'h0001, 8'd1, "R4 R2 signed lsb");
      run(1, 16'h1234, 16'h8000, 8'd5, "R4 R2 signed msb carry");
      run(1, 16'h0003, 16'hFFFF, 8'd255, "R4 R2 signed neg one");
      run(1, 16'hFF85, 16'h7ACE, 8'd4, "R2 signed mixed");
      run(1, 16'h8000, 16'h8000, 8'd1, "R2 signed min squared");

      // R8 start while busy ignored
      issue(0, 16'h0102, 16'h0003, 8'd2, "R8 first op");
      repeat (5) @(negedge clk);
      signed_mode = 1; mcand = 16'hFFFF; mplier = 16'h5555; clk_div = 8'd9; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      repeat (80) @(negedge clk);
      check(sb.size() == 0, "R8 queue drained", sb.size(), 0);

      // R9 result holds while idle
      run(1, 16'h4000, 16'h0F0F, 8'd6, "R9 op");
      begin
         logic [31:0] p0;
         logic [6:0]  c0;
         logic [14:0] m0;
         p0 = product; c0 = core_cycles; m0 = master_cycles;
         mcand = 16'h5A5A; mplier = 16'hA5A5; clk_div = 8'd77; signed_mode = 0;
         repeat (20) @(negedge clk);
         check(product == p0, "R9 product hold", product, p0);
         check(core_cycles == c0 && master_cycles == m0, "R9 counts hold",
               {core_cycles, master_cycles}, {c0, m0});
         check(!busy && !done, "R9 stays idle", {busy, done}, 0);
      end

      finished = 1;
   end

   initial begin
      while (!finished && cyc < 20000) @(negedge clk);
      if (!finished) check(0, "watchdog", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule